// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block answers a host interrupt-acknowledge cycle. When the host pulls the acknowledge request low, the block takes a snapshot of four inputs: the programmed base vector, the 2-bit format-select field, the number of the winning channel and the 3-bit cause code. It merges them into an 8-bit vector and presents it on the data bus for the duration of the cycle. It then ends the cycle with a one-clock, active-low data-acknowledge strobe.

The format-select field chooses one of four layouts. In the first, the whole base vector is used. In the second, the channel number fills the two lowest bits. In the third, the channel number and the cause code fill the five lowest bits. The fourth puts nothing on the bus, but the strobe is still sent. The vector leaves on `vec_data` together with a drive enable `vec_oe`. The enable controls the chip-level tri-state pad, and the pad floats whenever `vec_oe` is low.

Arbitration and bus address decoding sit upstream of this block. The acknowledge request is expected to be synchronous to `clk`.

Top module: `iack_vector_gen`

## Requirements
- R1: While reset is applied, and after reset until the first acknowledge request, `vec_oe` is 0 and `dack_n` is 1.
- R2: Format code 0: the driven vector equals the base vector on all eight bits.
- R3: Format code 1: vector bits 7:2 are base bits 7:2, and bits 1:0 are the channel number.
- R4: Format code 2: vector bits 7:5 are base bits 7:5, bits 4:3 are the channel number, and bits 2:0 are the cause code.
- R5: Format code 3: `vec_oe` stays 0 for the whole cycle, and the `dack_n` strobe is still issued.
- R6: `dack_n` is low for exactly one clock. It goes low at the third rising edge, counting the edge that first samples `iack_n` low as the first.
- R7: For formats 0 to 2, `vec_oe` rises at the edge that samples the request and stays high through the strobe clock. It is low after the strobe ends.
- R8: The format, base vector, channel and cause are captured when the cycle starts. Changing them during the cycle leaves the driven vector unchanged.
- R9: `vec_oe` falls in the same clock that `iack_n` is released, even if that happens before the strobe. A cycle that has started still ends with its strobe at the usual time.
- R10: Holding `iack_n` low after the strobe starts no new cycle. Only one strobe is produced until `iack_n` has been seen high.
- R11: `vec_data` reads 0 whenever `vec_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| base_vec | input | 8 | Programmed base vector |
| vec_fmt | input | 2 | Format select: 0 base, 1 base+channel, 2 base+channel+cause, 3 no vector |
| chan_id | input | 2 | Number of the channel that won arbitration |
| cause_id | input | 3 | Interrupt cause code of the winner |
| iack_n | input | 1 | Active-low acknowledge request from the host |
| vec_data | output | 8 | Vector for the bus pad, 0 while not driven |
| vec_oe | output | 1 | Pad drive enable; the bus floats when low |
| dack_n | output | 1 | Active-low one-clock data-acknowledge strobe |

## Verification
Take the rising edge that first samples `iack_n` low as edge 0. The vector and `vec_oe` are due in the half clock after edge 0. The strobe is due in the half clock after edge 2, and both the strobe and `vec_oe` are due to be gone after edge 3. Because `vec_oe` depends directly on `iack_n` (R9), it is checked one time step after `iack_n` is released. The stimulus changes on falling edges and every check samples on the falling edge that follows the due rising edge. Each result is therefore read half a clock after the register that produces it has updated.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

  typedef enum logic [1:0] {
    FMT_BASE      = 2'd0,
    FMT_CHAN      = 2'd1,
    FMT_CHAN_TYPE = 2'd2,
    FMT_NONE      = 2'd3
  } vfmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_DONE = 2'd3
  } ackst_e;

endpackage

// File: rtl/ivg_rst_sync.sv
module ivg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ivg_capture.sv
module ivg_capture #(
  parameter int VEC_W  = 8,
  parameter int CHAN_W = 2,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [VEC_W-1:0]  base_in,
  input  logic [1:0]        fmt_in,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [TYPE_W-1:0] type_in,
  output logic [VEC_W-1:0]  base_q,
  output logic [1:0]        fmt_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic [TYPE_W-1:0] type_q
);

  logic [VEC_W-1:0]  base_d;
  logic [1:0]        fmt_d;
  logic [CHAN_W-1:0] chan_d;
  logic [TYPE_W-1:0] type_d;

  // next-state: hold unless a new cycle is starting
  always_comb begin
    base_d = base_q;
    fmt_d  = fmt_q;
    chan_d = chan_q;
    type_d = type_q;
    if (load) begin
      base_d = base_in;
      fmt_d  = fmt_in;
      chan_d = chan_in;
      type_d = type_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      fmt_q  <= ivg_pkg::FMT_NONE;
      chan_q <= '0;
      type_q <= '0;
    end else begin
      base_q <= base_d;
      fmt_q  <= fmt_d;
      chan_q <= chan_d;
      type_q <= type_d;
    end
  end

endmodule

// File: rtl/ivg_merge.sv
module ivg_merge #(
  parameter int VEC_W  = 8,
  parameter int CHAN_W = 2,
  parameter int TYPE_W = 3
) (
  input  logic [1:0]        fmt,
  input  logic [VEC_W-1:0]  base,
  input  logic [CHAN_W-1:0] chan,
  input  logic [TYPE_W-1:0] cause,
  output logic [VEC_W-1:0]  vec
);

  import ivg_pkg::*;

  localparam int LOW_CT = CHAN_W + TYPE_W;

  logic [VEC_W-1:0] v_chan;
  logic [VEC_W-1:0] v_chan_type;

  generate
    if (VEC_W > LOW_CT) begin : g_wide
      assign v_chan      = {base[VEC_W-1:CHAN_W], chan};
      assign v_chan_type = {base[VEC_W-1:LOW_CT], chan, cause};
    end else begin : g_narrow
      assign v_chan      = {base[VEC_W-1:CHAN_W], chan};
      assign v_chan_type = VEC_W'({chan, cause});
    end
  endgenerate

  always_comb begin
    case (vfmt_e'(fmt))
      FMT_CHAN:      vec = v_chan;
      FMT_CHAN_TYPE: vec = v_chan_type;
      default:       vec = base;
    endcase
  end

endmodule

// File: rtl/ivg_seq.sv
module ivg_seq #(
  parameter int ACK_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iack_n,
  output logic load,
  output logic window,
  output logic strobe
);

  import ivg_pkg::*;

  localparam int CNT_W = (ACK_DLY > 1) ? $clog2(ACK_DLY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DLY - 1);

  ackst_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (!iack_n) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_ACK;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ACK:  state_d = ST_DONE;
      ST_DONE: if (iack_n) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load   = (state_q == ST_IDLE) && !iack_n;
  assign window = (state_q == ST_WAIT) || (state_q == ST_ACK);
  assign strobe = (state_q == ST_ACK);

  // R10: a finished cycle waits for the request to be released
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !iack_n) |=> (state_q == ST_DONE));

  // R6: strobe is a single clock
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R6: strobe only follows the delay phase
  a_r6_strobe_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(state_q == ST_WAIT));

endmodule

// File: rtl/iack_vector_gen.sv
module iack_vector_gen #(
  parameter int VEC_W   = 8,
  parameter int CHAN_W  = 2,
  parameter int TYPE_W  = 3,
  parameter int ACK_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  base_vec,
  input  logic [1:0]        vec_fmt,
  input  logic [CHAN_W-1:0] chan_id,
  input  logic [TYPE_W-1:0] cause_id,
  input  logic              iack_n,
  output logic [VEC_W-1:0]  vec_data,
  output logic              vec_oe,
  output logic              dack_n
);

  import ivg_pkg::*;

  logic              rst_sync_n;
  logic              load;
  logic              window;
  logic              strobe;
  logic [VEC_W-1:0]  base_q;
  logic [1:0]        fmt_q;
  logic [CHAN_W-1:0] chan_q;
  logic [TYPE_W-1:0] type_q;
  logic [VEC_W-1:0]  merged;

  ivg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ivg_seq #(.ACK_DLY(ACK_DLY)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .iack_n (iack_n),
    .load   (load),
    .window (window),
    .strobe (strobe)
  );

  ivg_capture #(.VEC_W(VEC_W), .CHAN_W(CHAN_W), .TYPE_W(TYPE_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .base_in (base_vec),
    .fmt_in  (vec_fmt),
    .chan_in (chan_id),
    .type_in (cause_id),
    .base_q  (base_q),
    .fmt_q   (fmt_q),
    .chan_q  (chan_q),
    .type_q  (type_q)
  );

  ivg_merge #(.VEC_W(VEC_W), .CHAN_W(CHAN_W), .TYPE_W(TYPE_W)) u_mrg (
    .fmt   (fmt_q),
    .base  (base_q),
    .chan  (chan_q),
    .cause (type_q),
    .vec   (merged)
  );

  assign vec_oe   = window && (fmt_q != FMT_NONE) && !iack_n && rst_sync_n;
  assign vec_data = vec_oe ? merged : '0;
  assign dack_n   = !strobe;

  // R7, R9: never drive without an active request
  a_r9_oe_needs_iack: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_oe |-> !iack_n);

  // R5: the no-vector format never drives the bus
  a_r5_silent_format: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fmt_q == FMT_NONE) |-> !vec_oe);

  // R8: a vector held across two clocks does not change
  a_r8_vec_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_data));

  // R11: an idle bus value is zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !vec_oe |-> (vec_data == '0));

  // R7: drive ends once the strobe is over
  a_r7_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dack_n |=> !vec_oe);

endmodule

// File: tb/sim_iack_vector_gen.sv
module sim_iack_vector_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] base_vec;
  logic [1:0] vec_fmt;
  logic [1:0] chan_id;
  logic [2:0] cause_id;
  logic       iack_n;
  logic [7:0] vec_data;
  logic       vec_oe;
  logic       dack_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  iack_vector_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_vec (base_vec),
    .vec_fmt  (vec_fmt),
    .chan_id  (chan_id),
    .cause_id (cause_id),
    .iack_n   (iack_n),
    .vec_data (vec_data),
    .vec_oe   (vec_oe),
    .dack_n   (dack_n)
  );

  // {fmt, base, chan, cause, expected vector}; format 3 expects no drive
  localparam logic [22:0] TBL [0:7] = '{
    {2'd0, 8'hA5, 2'd3, 3'd7, 8'hA5},   // R2
    {2'd0, 8'h00, 2'd1, 3'd2, 8'h00},   // R2
    {2'd1, 8'hA5, 2'd2, 3'd0, 8'hA6},   // R3
    {2'd1, 8'hFF, 2'd0, 3'd5, 8'hFC},   // R3
    {2'd2, 8'hA5, 2'd3, 3'd5, 8'hBD},   // R4
    {2'd2, 8'h1F, 2'd0, 3'd0, 8'h00},   // R4
    {2'd2, 8'h40, 2'd1, 3'd6, 8'h4E},   // R4
    {2'd3, 8'hA5, 2'd2, 3'd4, 8'h00}    // R5
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_cycle(input logic [1:0] f, input logic [7:0] b,
                             input logic [1:0] c, input logic [2:0] t);
    vec_fmt  = f;
    base_vec = b;
    chan_id  = c;
    cause_id = t;
    iack_n   = 1'b0;
  endtask

  // one full acknowledge cycle, checks at each due falling edge
  task automatic run_row(input logic [22:0] row);
    logic [1:0] f;
    logic [7:0] expv;
    bit         drv;
    f    = row[22:21];
    expv = row[7:0];
    drv  = (f != 2'd3);
    start_cycle(f, row[20:13], row[12:11], row[10:8]);
    @(negedge clk);  // after edge 0
    chk(vec_oe == drv, "R7 oe at start", vec_oe, drv);
    if (drv) chk(vec_data == expv, f == 2'd0 ? "R2 vector" : (f == 2'd1 ? "R3 vector" : "R4 vector"),
                 vec_data, expv);
    else     chk(vec_data == 8'h00, "R11 idle data", vec_data, 0);
    chk(dack_n == 1'b1, "R6 no early strobe", dack_n, 1);
    @(negedge clk);  // after edge 1
    chk(dack_n == 1'b1, "R6 no early strobe", dack_n, 1);
    @(negedge clk);  // after edge 2
    chk(dack_n == 1'b0, f == 2'd3 ? "R5 strobe in silent format" : "R6 strobe due", dack_n, 0);
    chk(vec_oe == drv, f == 2'd3 ? "R5 no drive" : "R7 oe during strobe", vec_oe, drv);
    iack_n = 1'b1;
    @(negedge clk);  // after edge 3
    chk(dack_n == 1'b1, "R6 strobe one clock", dack_n, 1);
    chk(vec_oe == 1'b0, "R7 oe off after strobe", vec_oe, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int low_cnt;
    rst_n    = 1'b0;
    iack_n   = 1'b1;
    base_vec = 8'h00;
    vec_fmt  = 2'd0;
    chan_id  = 2'd0;
    cause_id = 3'd0;
    repeat (3) @(negedge clk);
    chk(vec_oe == 1'b0, "R1 oe in reset", vec_oe, 0);
    chk(dack_n == 1'b1, "R1 dack in reset", dack_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(vec_oe == 1'b0, "R1 oe after reset", vec_oe, 0);
    chk(dack_n == 1'b1, "R1 dack after reset", dack_n, 1);
    chk(vec_data == 8'h00, "R11 data after reset", vec_data, 0);

    for (int i = 0; i < 8; i++) run_row(TBL[i]);

    // R8: inputs change mid-cycle, vector holds
    start_cycle(2'd2, 8'hA5, 2'd3, 3'd5);
    @(negedge clk);
    chk(vec_data == 8'hBD, "R8 initial vector", vec_data, 8'hBD);
    vec_fmt = 2'd3; base_vec = 8'h00; chan_id = 2'd0; cause_id = 3'd0;
    @(negedge clk);
    chk(vec_oe == 1'b1, "R8 oe kept", vec_oe, 1);
    chk(vec_data == 8'hBD, "R8 vector held", vec_data, 8'hBD);
    @(negedge clk);
    chk(vec_data == 8'hBD, "R8 vector held at strobe", vec_data, 8'hBD);
    iack_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: early release drops drive at once, strobe still due
    start_cycle(2'd0, 8'h3C, 2'd0, 3'd0);
    @(negedge clk);
    chk(vec_oe == 1'b1, "R9 oe before release", vec_oe, 1);
    iack_n = 1'b1;
    #1;
    chk(vec_oe == 1'b0, "R9 oe drops on release", vec_oe, 0);
    chk(vec_data == 8'h00, "R11 data on release", vec_data, 0);
    @(negedge clk);
    chk(dack_n == 1'b1, "R9 no early strobe", dack_n, 1);
    @(negedge clk);
    chk(dack_n == 1'b0, "R9 strobe still issued", dack_n, 0);
    repeat (2) @(negedge clk);

    // R10: request held low long after the strobe
    start_cycle(2'd1, 8'h80, 2'd1, 3'd0);
    low_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!dack_n) low_cnt++;
      if (k >= 3) chk(vec_oe == 1'b0, "R10 no drive while held", vec_oe, 0);
    end
    chk(low_cnt == 1, "R10 single strobe while held", low_cnt, 1);
    iack_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: after release a new cycle works again
    run_row({2'd1, 8'h80, 2'd1, 3'd0, 8'h81});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule